// File: doc/BRIEF.md
# Approximate Recursive Unsigned Multiplier

This block multiplies two unsigned N-bit operands into a 2N-bit product. The product is built from small 2x2-bit partial-product cells, composed recursively. A 2k-bit multiply is split into four k-bit multiplies whose results are shifted and summed. Each leaf cell is simplified so that its result fits in three bits. For the one operand pair where both 2-bit inputs are 3, the cell returns 7 rather than 9, so the assembled product is inexact for some operand values.

A mode input chooses between two behaviours. In approximate mode the small error is accepted in return for cheaper logic. In exact mode a correction path adds 2 to every leaf result whose operands are both 3. The sum is then the true product, so software that cannot tolerate error can use the same datapath.

The mode and both operands are taken on the cycle the input strobe is high. The result appears a fixed number of cycles later:
- one cycle when the optional output register is fitted;
- zero cycles when it is left out.

Top module: `amul_top`

## Requirements
- R1: A leaf cell multiplying 2-bit values x and y returns the exact product x*y for every pair except x=3, y=3, where it returns 7. With N=8 and approximate mode, 3*3 yields 7 and 2*3 yields 6.
- R2: With `mode_exact`=1, `product` equals the true unsigned product `op_a`*`op_b` for every operand pair.
- R3: With `mode_exact`=0, `product` equals the sum over all 2-bit digit pairs of a[2i+1:2i] and b[2j+1:2j] of cell(digit_a, digit_b) shifted left by 2(i+j). Here cell() is the R1 mapping. For all-ones operands at N=8 this gives 50575.
- R4: In approximate mode `product` never exceeds the true product, so the 2N-bit output never wraps.
- R5: If either operand is zero, `product` is zero in both modes.
- R6: When `OUT_REG`=1, `out_vld` and `product` appear exactly one cycle after an input cycle with `in_vld`=1. They reflect the operands and mode of that cycle, and later changes to the inputs do not alter them. When `OUT_REG`=0, the latency is zero.
- R7: `out_vld` is 0 while `rst_n` is low, and it is 0 in the cycle after an input cycle with `in_vld`=0.
- R8: Only widths N of 2, 4, 8 or 16 elaborate; any other width stops elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_vld | input | 1 | Operands and mode are valid this cycle |
| mode_exact | input | 1 | 1 = corrected exact product, 0 = approximate product |
| op_a | input | N | Multiplicand, unsigned |
| op_b | input | N | Multiplier, unsigned |
| out_vld | output | 1 | Product is valid |
| product | output | 2N | Unsigned product |

## Verification
The assertions assume that reset is applied at the start. They also assume that operands and mode carry known values whenever the strobe is high, because they compare the output against a product computed from the captured inputs.

The bench drives every input from reset onward and never leaves one undriven. It sweeps every operand pair in both modes, one pair per cycle, so each compared result traces to a single known input cycle. Directed cases then change the inputs just after a capture edge and hold the strobe low, to probe mode sampling and the valid flag.

// File: rtl/amul_pkg.sv
package amul_pkg;

   typedef enum logic {
      MODE_APPROX = 1'b0,
      MODE_EXACT  = 1'b1
   } mul_mode_e;

   // Leaf digit width of the recursion.
   localparam int unsigned LEAF_W = 2;

   // Value added to a flagged leaf result when exact mode is active (9 - 7).
   localparam logic [3:0] LEAF_FIX = 4'd2;

   function automatic bit width_ok(input int unsigned w);
      return (w == 2) || (w == 4) || (w == 8) || (w == 16);
   endfunction

endpackage

// File: rtl/amul_cell2.sv
module amul_cell2 (
   input  logic [1:0] x,
   input  logic [1:0] y,
   output logic [2:0] p,
   output logic       both3
);
   // Three-bit product. The middle bit ORs the cross terms, so 3x3 collapses to 7.
   always_comb begin
      p[0]  = x[0] & y[0];
      p[1]  = (x[1] & y[0]) | (x[0] & y[1]);
      p[2]  = x[1] & y[1];
      both3 = &{x, y};
   end
endmodule

// File: rtl/amul_rec.sv
module amul_rec #(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   input  logic           fix_en,
   output logic [2*W-1:0] prod
);
   import amul_pkg::*;

   localparam int unsigned H = W / 2;

   generate
      if (W == LEAF_W) begin : g_leaf
         logic [2:0] cell_p;
         logic       cell_f;

         amul_cell2 u_cell (
            .x     (a),
            .y     (b),
            .p     (cell_p),
            .both3 (cell_f)
         );

         // Correction path: restore 9 from the collapsed 7.
         always_comb begin
            prod = {1'b0, cell_p} + ((fix_en && cell_f) ? LEAF_FIX : 4'd0);
         end
      end else begin : g_split
         logic [W-1:0] pp_hh;
         logic [W-1:0] pp_hl;
         logic [W-1:0] pp_lh;
         logic [W-1:0] pp_ll;
         logic [W:0]   mid_sum;

         amul_rec #(.W(H)) u_hh (
            .a(a[W-1:H]), .b(b[W-1:H]), .fix_en(fix_en), .prod(pp_hh)
         );
         amul_rec #(.W(H)) u_hl (
            .a(a[W-1:H]), .b(b[H-1:0]), .fix_en(fix_en), .prod(pp_hl)
         );
         amul_rec #(.W(H)) u_lh (
            .a(a[H-1:0]), .b(b[W-1:H]), .fix_en(fix_en), .prod(pp_lh)
         );
         amul_rec #(.W(H)) u_ll (
            .a(a[H-1:0]), .b(b[H-1:0]), .fix_en(fix_en), .prod(pp_ll)
         );

         // Adder tree: the two cross terms first, then merge with the
         // high and low terms. Those two do not overlap, so a concatenation suffices.
         always_comb begin
            mid_sum = {1'b0, pp_hl} + {1'b0, pp_lh};
            prod    = {pp_hh, pp_ll} + ({{(W-1){1'b0}}, mid_sum} << H);
         end
      end
   endgenerate
endmodule

// File: rtl/amul_outstage.sv
module amul_outstage #(
   parameter int unsigned W   = 16,
   parameter bit          REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         vld_in,
   input  logic [W-1:0] dat_in,
   output logic         vld_out,
   output logic [W-1:0] dat_out
);
   generate
      if (REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_out <= 1'b0;
               dat_out <= '0;
            end else begin
               vld_out <= vld_in;
               dat_out <= dat_in;
            end
         end
      end else begin : g_wire
         always_comb begin
            vld_out = rst_n & vld_in;
            dat_out = dat_in;
         end
      end
   endgenerate
endmodule

// File: rtl/amul_top.sv
module amul_top #(
   parameter int unsigned N       = 8,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           in_vld,
   input  logic           mode_exact,
   input  logic [N-1:0]   op_a,
   input  logic [N-1:0]   op_b,
   output logic           out_vld,
   output logic [2*N-1:0] product
);
   import amul_pkg::*;

   localparam int unsigned PW = 2 * N;

   // R8: elaboration-time width check
   generate
      if (!width_ok(N)) begin : g_bad_width
         $error("amul_top: N must be 2, 4, 8 or 16");
      end
   endgenerate

   mul_mode_e      mode_q;
   logic [PW-1:0]  raw_prod;

   assign mode_q = mul_mode_e'(mode_exact);

   amul_rec #(.W(N)) u_core (
      .a      (op_a),
      .b      (op_b),
      .fix_en (mode_q == MODE_EXACT),
      .prod   (raw_prod)
   );

   amul_outstage #(.W(PW), .REG(OUT_REG)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .vld_in  (in_vld),
      .dat_in  (raw_prod),
      .vld_out (out_vld),
      .dat_out (product)
   );
endmodule

// File: rtl/amul_chk.sv
module amul_chk #(
   parameter int unsigned N       = 8,
   parameter bit          OUT_REG = 1'b1
) (
   input logic           clk,
   input logic           rst_n,
   input logic           in_vld,
   input logic           mode_exact,
   input logic [N-1:0]   op_a,
   input logic [N-1:0]   op_b,
   input logic           out_vld,
   input logic [2*N-1:0] product
);
   logic [N-1:0]   ref_a;
   logic [N-1:0]   ref_b;
   logic           ref_m;
   logic           ref_v;
   logic [2*N-1:0] ref_p;

   generate
      if (OUT_REG) begin : g_lat1
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ref_a <= '0;
               ref_b <= '0;
               ref_m <= 1'b0;
               ref_v <= 1'b0;
            end else begin
               ref_a <= op_a;
               ref_b <= op_b;
               ref_m <= mode_exact;
               ref_v <= in_vld;
            end
         end

         // R6 / R7: valid follows the strobe by one cycle
         p_vld_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
            in_vld |=> out_vld);
         p_vld_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !in_vld |=> !out_vld);
      end else begin : g_lat0
         always_comb begin
            ref_a = op_a;
            ref_b = op_b;
            ref_m = mode_exact;
            ref_v = in_vld;
         end

         p_vld_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
            out_vld == in_vld);
      end
   endgenerate

   assign ref_p = {{N{1'b0}}, ref_a} * {{N{1'b0}}, ref_b};

   p_exact_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && ref_v && ref_m) |-> (product == ref_p));

   p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && ref_v && !ref_m) |-> (product <= ref_p));

   p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && ref_v && ((ref_a == '0) || (ref_b == '0))) |-> (product == '0));
endmodule

bind amul_top amul_chk #(.N(N), .OUT_REG(OUT_REG)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_vld     (in_vld),
   .mode_exact (mode_exact),
   .op_a       (op_a),
   .op_b       (op_b),
   .out_vld    (out_vld),
   .product    (product)
);

// File: tb/amul_top_test.sv
module amul_top_test;
   localparam int N        = 8;
   localparam int CLK_HALF = 5;
   localparam int WATCHDOG = 195000;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           in_vld = 1'b0;
   logic           mode_exact = 1'b0;
   logic [N-1:0]   op_a = '0;
   logic [N-1:0]   op_b = '0;
   logic           out_vld;
   logic [2*N-1:0] product;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #CLK_HALF clk = ~clk;

   amul_top #(.N(N), .OUT_REG(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .mode_exact(mode_exact),
      .op_a(op_a), .op_b(op_b), .out_vld(out_vld), .product(product)
   );

   // Digit-pair model of the approximate product (R1 cell, R3 composition)
   function automatic int cell_val(input int x, input int y);
      return (x == 3 && y == 3) ? 7 : x * y;
   endfunction

   function automatic int approx_ref(input int a, input int b);
      int s = 0;
      for (int i = 0; i < N / 2; i++)
         for (int j = 0; j < N / 2; j++)
            s += cell_val((a >> (2 * i)) & 3, (b >> (2 * j)) & 3) << (2 * (i + j));
      return s;
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Called at a negedge: drive, wait one cycle, return at next negedge
   task automatic step(input int a, input int b, input bit m, input bit v);
      op_a = N'(a);
      op_b = N'(b);
      mode_exact = m;
      in_vld = v;
      @(negedge clk);
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R7 reset out_vld", int'(out_vld), 0);
      rst_n = 1'b1;

      // R1 directed leaf cases
      step(3, 3, 1'b0, 1'b1);
      chk("R1 3x3 approx", int'(product), 7);
      chk("R6 valid after strobe", int'(out_vld), 1);
      step(2, 3, 1'b0, 1'b1);
      chk("R1 2x3 approx", int'(product), 6);
      step(3, 3, 1'b1, 1'b1);
      chk("R2 3x3 exact", int'(product), 9);

      // R3 all-ones corner, R2 exact counterpart
      step(255, 255, 1'b0, 1'b1);
      chk("R3 all-ones approx", int'(product), 50575);
      step(255, 255, 1'b1, 1'b1);
      chk("R2 all-ones exact", int'(product), 65025);

      // R7 strobe low
      step(7, 9, 1'b1, 1'b0);
      chk("R7 idle out_vld", int'(out_vld), 0);

      // R6 mode and operands sampled only at the capture edge
      op_a = 8'd3; op_b = 8'd3; mode_exact = 1'b0; in_vld = 1'b1;
      @(posedge clk);
      #1;
      mode_exact = 1'b1; op_a = 8'd0; in_vld = 1'b0;
      @(negedge clk);
      chk("R6 held product", int'(product), 7);
      chk("R6 held valid", int'(out_vld), 1);

      // Exhaustive sweep, both modes
      for (int m = 0; m < 2; m++) begin
         for (int a = 0; a < (1 << N); a++) begin
            for (int b = 0; b < (1 << N); b++) begin
               step(a, b, m[0], 1'b1);
               if (m == 1) begin
                  chk("R2 exact sweep", int'(product), a * b);
               end else begin
                  chk("R3 approx sweep", int'(product), approx_ref(a, b));
                  checks++;
                  if (int'(product) > a * b) begin
                     errors++;
                     $display("FAIL R4 actual=%0d expected<=%0d", product, a * b);
                  end
               end
               if (a == 0 || b == 0)
                  chk("R5 zero operand", int'(product), 0);
            end
         end
      end

      // R8 holds by elaborating at N=8; confirm output width
      chk("R8 product width", $bits(product), 16);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule